// File: doc/BRIEF.md
# Dual-Capture Up-Counting Timer

This block is a 16-bit up-counter with a programmable count source, an optional clear-on-compare, and two capture registers. Each capture register stores a snapshot of the count when a chosen input edge occurs. The count advances by one on each pulse of the selected source. That source is either rising edges of an external pin or one of three prescaled tick strobes. Every source acts as a one-cycle enable on the system clock.

A small mode register sets how the block behaves. Bits 1:0 pick the count source. Bit 2 turns on clear-on-compare. Bits 4:3 pick which edges load the two capture registers. Writing bit 5 as 0 takes an immediate software snapshot into capture register 0. Software reaches the registers through a plain write-enable bus with a combinational read port. The address map is: 0 mode, 1 compare, 2 capture 0, 3 capture 1, 4 live count.

All three external edge sources pass through a two-stage synchroniser. An edge is found by comparing the synchronised level with its value one cycle earlier. The edge sources are pin A, pin B and a timer-output signal from a neighbouring timer.

Top module: `cap_timer`

## Requirements
- R1: After reset, these registers read 0: count (addr 4), capture 0 (addr 2), capture 1 (addr 3) and compare (addr 1). The mode register (addr 0) reads 0x0020, and unmapped addresses 5 to 7 read 0.
- R2: Mode bits 1:0 select the count source: 00 counts rising edges of pin A, 01 counts tick1 pulses, 10 counts tick4 pulses, 11 counts tick16 pulses. Each enable adds exactly one, and pulses on sources that are not selected leave the count unchanged.
- R3: When mode bit 2 is 0, a count enable at 0xFFFF takes the count to 0x0000.
- R4: When mode bit 2 is 1, a count enable while the count equals the compare register loads 0 instead of incrementing. When bit 2 is 0, the count passes the compare value.
- R5: Capture mode 00 (mode bits 4:3) performs no hardware capture on any edge.
- R6: Capture mode 01 loads the count into capture 0 on a rising edge of pin A, and into capture 1 on a rising edge of pin B. Falling edges and the timer-output signal are ignored.
- R7: Capture mode 10 loads capture 0 on a rising edge of pin A and capture 1 on a falling edge of pin A. Pin B is ignored.
- R8: Capture mode 11 loads capture 0 on a rising edge of the timer-output signal and capture 1 on its falling edge. Pin A is ignored.
- R9: A write to the mode register with wdata bit 5 equal to 0 loads the current count into capture 0 at that clock edge. A mode write with bit 5 equal to 1 leaves capture 0 unchanged.
- R10: When a software capture and a hardware capture into capture 0 fall on the same clock edge, capture 0 holds the count of that cycle, and the count keeps advancing undisturbed.
- R11: The mode register stores only wdata bits 4:0. On read, bits 7:6 are 0, bit 5 is 1, and bits 15:8 are 0.
- R12: Each edge input has a two-flop synchroniser. A change applied before clock edge k is acted on at edge k+2, so a hardware capture stores the count held just before edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data of the addressed register |
| pin_a | input | 1 | External pin A: count source and capture trigger |
| pin_b | input | 1 | External pin B: capture trigger |
| tmr_out | input | 1 | Output of a neighbouring timer, used as a capture trigger |
| tick1 | input | 1 | Prescaled tick strobe, finest rate |
| tick4 | input | 1 | Prescaled tick strobe, divide by 4 |
| tick16 | input | 1 | Prescaled tick strobe, divide by 16 |

## Verification
Two actions can load capture register 0 on the same clock edge: a software snapshot from a mode write with bit 5 clear, and a hardware capture from a synchronised pin A rise. The bench keeps tick1 running so the count changes every cycle. It raises pin A, then issues the mode write exactly two cycles later, so both captures land on the same edge. It then checks that capture 0 holds the count from two cycles after the pin change, and that the count has reached its expected value with the mode unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'b00,
        SRC_TICK1 = 2'b01,
        SRC_TICK4 = 2'b10,
        SRC_TICK16 = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CAPM_OFF      = 2'b00,
        CAPM_TWO_PINS = 2'b01,
        CAPM_A_BOTH   = 2'b10,
        CAPM_TMR_BOTH = 2'b11
    } capm_e;

    typedef struct packed {
        capm_e capm;
        logic  clr_en;
        src_e  src;
    } mode_t;

    localparam int MODE_BITS = $bits(mode_t);

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_CMP  = 3'd1;
    localparam logic [2:0] A_CAP0 = 3'd2;
    localparam logic [2:0] A_CAP1 = 3'd3;
    localparam logic [2:0] A_CNT  = 3'd4;

    localparam int LANE_A   = 0;
    localparam int LANE_B   = 1;
    localparam int LANE_TMR = 2;
    localparam int N_LANES  = 3;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int PW = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_lane
        logic [PW-1:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[PW-2:0], din[i]};
        end

        // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
        assign rise[i] =  pipe[STAGES-1] & ~pipe[STAGES];
        assign fall[i] = ~pipe[STAGES-1] &  pipe[STAGES];
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_en,
    input  logic         clr_en,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count
);
    logic hit;
    assign hit = clr_en && (count == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (cnt_en) count <= hit ? '0 : count + W'(1);
    end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  capm_e              capm,
    input  logic [N_LANES-1:0] rise,
    input  logic [N_LANES-1:0] fall,
    input  logic               sw_cap,
    input  logic [W-1:0]       count,
    output logic [W-1:0]       cap0,
    output logic [W-1:0]       cap1
);
    logic hw0, hw1;

    always_comb begin
        unique case (capm)
            CAPM_OFF: begin
                hw0 = 1'b0;
                hw1 = 1'b0;
            end
            CAPM_TWO_PINS: begin
                hw0 = rise[LANE_A];
                hw1 = rise[LANE_B];
            end
            CAPM_A_BOTH: begin
                hw0 = rise[LANE_A];
                hw1 = fall[LANE_A];
            end
            CAPM_TMR_BOTH: begin
                hw0 = rise[LANE_TMR];
                hw1 = fall[LANE_TMR];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap0 <= '0;
            cap1 <= '0;
        end else begin
            if (hw0 || sw_cap) cap0 <= count;
            if (hw1)           cap1 <= count;
        end
    end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              tmr_out,
    input  logic              tick1,
    input  logic              tick4,
    input  logic              tick16
);
    localparam int SW_BIT = MODE_BITS;

    mode_t              mode_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   count, cap0, cap1;
    logic [N_LANES-1:0] rise, fall;
    logic               cnt_en, sw_cap, mode_wr, clr_en_w;
    logic [1:0]         capm_w;

    assign mode_wr  = wr_en && (addr == ADDR_W'(A_MODE));
    assign sw_cap   = mode_wr && !wdata[SW_BIT];
    assign clr_en_w = mode_q.clr_en;
    assign capm_w   = mode_q.capm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MODE)) mode_q <= mode_t'(wdata[MODE_BITS-1:0]);
            if (addr == ADDR_W'(A_CMP))  cmp_q  <= wdata;
        end
    end

    tmr_sync_edge #(.N(N_LANES), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({tmr_out, pin_b, pin_a}),
        .rise (rise),
        .fall (fall)
    );

    always_comb begin
        unique case (mode_q.src)
            SRC_PIN_A:  cnt_en = rise[LANE_A];
            SRC_TICK1:  cnt_en = tick1;
            SRC_TICK4:  cnt_en = tick4;
            SRC_TICK16: cnt_en = tick16;
        endcase
    end

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_en(cnt_en),
        .clr_en(mode_q.clr_en),
        .cmp   (cmp_q),
        .count (count)
    );

    tmr_capture #(.W(CNT_W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .capm  (mode_q.capm),
        .rise  (rise),
        .fall  (fall),
        .sw_cap(sw_cap),
        .count (count),
        .cap0  (cap0),
        .cap1  (cap1)
    );

    // Read mux: bit 5 of the mode register always reads 1 (write-only strobe)
    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(A_MODE): rdata = CNT_W'({1'b1, mode_q});
            ADDR_W'(A_CMP):  rdata = cmp_q;
            ADDR_W'(A_CAP0): rdata = cap0;
            ADDR_W'(A_CAP1): rdata = cap1;
            ADDR_W'(A_CNT):  rdata = count;
            default:         rdata = '0;
        endcase
    end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  rdata,
    input logic              cnt_en,
    input logic              clr_en,
    input logic [1:0]        capm,
    input logic [CNT_W-1:0]  cmp,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cap0,
    input logic [CNT_W-1:0]  cap1
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !(clr_en && count == cmp)) |=> (count == CNT_W'($past(count) + 1'b1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !clr_en && count == '1) |=> (count == '0));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && clr_en && count == cmp) |=> (count == '0));

    p_nocap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (capm == 2'b00 && !(wr_en && addr == '0 && !wdata[5])) |=> ($stable(cap0) && $stable(cap1)));

    p_swcap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0 && !wdata[5]) |=> (cap0 == $past(count)));

    p_moderd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata[7:5] == 3'b001 && rdata[CNT_W-1:8] == '0));
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .cnt_en(cnt_en),
    .clr_en(clr_en_w),
    .capm  (capm_w),
    .cmp   (cmp_q),
    .count (count),
    .cap0  (cap0),
    .cap1  (cap1)
);

// File: tb/tb_cap_timer.sv
`timescale 1ns/1ps
module tb_cap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pin_a = 1'b0, pin_b = 1'b0, tmr_out = 1'b0;
    logic        tick1 = 1'b0, tick4 = 1'b0, tick16 = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cap_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_a(pin_a), .pin_b(pin_b), .tmr_out(tmr_out),
        .tick1(tick1), .tick4(tick4), .tick16(tick16)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; pin_a = 1'b0; pin_b = 1'b0; tmr_out = 1'b0;
        tick1 = 1'b0; tick4 = 1'b0; tick16 = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic tick_pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            case (which)
                1: tick1 = 1'b1;
                4: tick4 = 1'b1;
                default: tick16 = 1'b1;
            endcase
            @(negedge clk);
            tick1 = 1'b0; tick4 = 1'b0; tick16 = 1'b0;
        end
    endtask

    task automatic set_pin(input int which, input logic v);
        case (which)
            0: pin_a = v;
            1: pin_b = v;
            default: tmr_out = v;
        endcase
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_pulse(input int which);
        set_pin(which, 1'b1);
        set_pin(which, 1'b0);
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1 mode", 3'd0, 16'h0020);
        rd_chk("R1 cmp", 3'd1, 16'h0000);
        rd_chk("R1 cap0", 3'd2, 16'h0000);
        rd_chk("R1 cap1", 3'd3, 16'h0000);
        rd_chk("R1 count", 3'd4, 16'h0000);
        rd_chk("R1 unmapped", 3'd6, 16'h0000);
    endtask

    task automatic t_source();
        do_reset();
        wr(3'd0, 16'h0020);
        pin_pulse(0); pin_pulse(0); pin_pulse(0);
        tick_pulse(1, 1); tick_pulse(4, 1); tick_pulse(16, 1);
        rd_chk("R2 pin A source", 3'd4, 16'd3);
        wr(3'd0, 16'h0022);
        tick_pulse(1, 1); tick_pulse(4, 1); tick_pulse(16, 1); tick_pulse(4, 1);
        pin_pulse(0);
        rd_chk("R2 tick4 source", 3'd4, 16'd5);
        wr(3'd0, 16'h0023);
        tick_pulse(16, 1); tick_pulse(4, 1);
        rd_chk("R2 tick16 source", 3'd4, 16'd6);
        wr(3'd0, 16'h0021);
        tick_pulse(1, 2); tick_pulse(16, 1);
        rd_chk("R2 tick1 source", 3'd4, 16'd8);
    endtask

    task automatic t_wrap();
        do_reset();
        wr(3'd0, 16'h0021);
        tick1 = 1'b1;
        repeat (65535) @(negedge clk);
        tick1 = 1'b0;
        rd_chk("R3 at max", 3'd4, 16'hFFFF);
        tick_pulse(1, 1);
        rd_chk("R3 wrap", 3'd4, 16'h0000);
    endtask

    task automatic t_clear();
        do_reset();
        wr(3'd1, 16'd5);
        wr(3'd0, 16'h0025);
        tick_pulse(1, 5);
        rd_chk("R4 reaches compare", 3'd4, 16'd5);
        tick_pulse(1, 1);
        rd_chk("R4 clear on match", 3'd4, 16'd0);
        tick_pulse(1, 1);
        rd_chk("R4 resumes", 3'd4, 16'd1);
        wr(3'd0, 16'h0021);
        wr(3'd1, 16'd1);
        tick_pulse(1, 1);
        rd_chk("R4 disabled passes compare", 3'd4, 16'd2);
    endtask

    task automatic t_capoff();
        do_reset();
        wr(3'd0, 16'h0021);
        tick_pulse(1, 7);
        pin_pulse(0); pin_pulse(1); pin_pulse(2);
        rd_chk("R5 cap0 untouched", 3'd2, 16'd0);
        rd_chk("R5 cap1 untouched", 3'd3, 16'd0);
    endtask

    task automatic t_mode01();
        do_reset();
        wr(3'd0, 16'h0029);
        tick_pulse(1, 4);
        pin_pulse(0);
        rd_chk("R6 pin A rise to cap0", 3'd2, 16'd4);
        rd_chk("R6 pin A fall ignored", 3'd3, 16'd0);
        tick_pulse(1, 3);
        pin_pulse(1);
        rd_chk("R6 pin B rise to cap1", 3'd3, 16'd7);
        tick_pulse(1, 1);
        pin_pulse(2);
        rd_chk("R6 timer output ignored cap0", 3'd2, 16'd4);
        rd_chk("R6 timer output ignored cap1", 3'd3, 16'd7);
    endtask

    task automatic t_mode10();
        do_reset();
        wr(3'd0, 16'h0031);
        tick_pulse(1, 3);
        set_pin(0, 1'b1);
        rd_chk("R7 pin A rise to cap0", 3'd2, 16'd3);
        tick_pulse(1, 2);
        set_pin(0, 1'b0);
        rd_chk("R7 pin A fall to cap1", 3'd3, 16'd5);
        tick_pulse(1, 1);
        pin_pulse(1);
        rd_chk("R7 pin B ignored", 3'd3, 16'd5);
    endtask

    task automatic t_mode11();
        do_reset();
        wr(3'd0, 16'h0039);
        tick_pulse(1, 2);
        set_pin(2, 1'b1);
        rd_chk("R8 timer rise to cap0", 3'd2, 16'd2);
        tick_pulse(1, 4);
        set_pin(2, 1'b0);
        rd_chk("R8 timer fall to cap1", 3'd3, 16'd6);
        tick_pulse(1, 1);
        pin_pulse(0);
        rd_chk("R8 pin A ignored", 3'd2, 16'd2);
    endtask

    task automatic t_sw();
        do_reset();
        wr(3'd0, 16'h0021);
        tick_pulse(1, 9);
        wr(3'd0, 16'h0001);
        rd_chk("R9 software capture", 3'd2, 16'd9);
        tick_pulse(1, 2);
        wr(3'd0, 16'h0021);
        rd_chk("R9 write one no effect", 3'd2, 16'd9);
        rd_chk("R9 cap1 untouched", 3'd3, 16'd0);
    endtask

    task automatic t_same_cycle();
        logic [15:0] c;
        do_reset();
        wr(3'd0, 16'h0029);
        tick1 = 1'b1;
        tick_pulse(1, 0);
        @(negedge clk);
        rd(3'd4, c);
        pin_a = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr = 3'd0; wdata = 16'h0009; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick1 = 1'b0;
        rd_chk("R10 both captures same value", 3'd2, c + 16'd2);
        rd_chk("R10 count undisturbed", 3'd4, c + 16'd3);
        rd_chk("R10 mode kept", 3'd0, 16'h0029);
    endtask

    task automatic t_latency();
        logic [15:0] c;
        do_reset();
        wr(3'd0, 16'h0029);
        tick1 = 1'b1;
        @(negedge clk);
        rd(3'd4, c);
        pin_a = 1'b1;
        repeat (3) @(negedge clk);
        tick1 = 1'b0;
        rd_chk("R12 two-flop latency", 3'd2, c + 16'd2);
    endtask

    task automatic t_mode_rd();
        do_reset();
        wr(3'd0, 16'h00FB);
        rd_chk("R11 upper bits dropped", 3'd0, 16'h003B);
        wr(3'd0, 16'hFFC4);
        rd_chk("R11 bit5 reads one", 3'd0, 16'h0024);
    endtask

    initial begin
        t_reset();
        t_source();
        t_wrap();
        t_clear();
        t_capoff();
        t_mode01();
        t_mode10();
        t_mode11();
        t_sw();
        t_same_cycle();
        t_latency();
        t_mode_rd();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule